// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block arbitrates interrupt requests for a simple processor core. Five request lines arrive with a fixed rank. Line 0 is a non-maskable trap and has the highest rank. Lines 1 to 3 are maskable restart requests. Line 4 is the maskable general request and has the lowest rank. One enable flip-flop decides whether the maskable lines may be accepted. The core pulses one input when it executes its enable-interrupt instruction and another when it executes its disable-interrupt instruction. The trap line does not depend on that flip-flop.

The core raises a boundary input in a cycle in which it has just finished an instruction. Requests are sampled only in such a cycle. When an eligible request is present, the block pulses a take output for one clock. In that same clock it gives the index of the winning line and asks the core to push its program counter. Accepting any request clears the enable flip-flop, so a further maskable request waits until the software enables interrupts again. Stack handling and vector generation belong to the core.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, take_o and push_pc_o are 0, src_o is 0 and ie_o is 0, so maskable lines start out disabled.
- R2: Among eligible requests, the one with the lowest bit index wins. Bit 0 is the trap, bits 1 to 3 are the restart lines and bit 4 is the general request. src_o carries the winner's bit index as a 3-bit binary number.
- R3: A trap request (req_i bit 0) sampled at a boundary is accepted whatever the value of ie_o.
- R4: A request on bits 1 to 4 is accepted only if ie_o was 1 in the sampling cycle. Otherwise it produces no take.
- R5: ie_o becomes 1 one cycle after ei_i is high and 0 one cycle after di_i is high. When both are high together, di_i wins.
- R6: Accepting a request clears ie_o in the same cycle that take_o is high. This holds even when ei_i was high in the sampling cycle.
- R7: Requests are sampled only in cycles with boundary_i high. take_o is high for exactly the one cycle after the sampling cycle, and src_o is valid in that cycle. src_o is 0 whenever take_o is 0.
- R8: A boundary_i that is high in a cycle in which take_o is high is not sampled, so two takes are never adjacent.
- R9: push_pc_o is high in exactly the cycles in which take_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request lines, bit 0 trap (highest) to bit 4 general (lowest) |
| boundary_i | input | 1 | High when the core is at an instruction boundary |
| ei_i | input | 1 | Enable-interrupt instruction pulse |
| di_i | input | 1 | Disable-interrupt instruction pulse |
| take_o | output | 1 | One-cycle pulse: a request was accepted |
| src_o | output | 3 | Index of the accepted line while take_o is high |
| push_pc_o | output | 1 | Tells the core to push its program counter |
| ie_o | output | 1 | Current state of the enable flip-flop |

## Verification
If the enable flip-flop held a wrong value, it would show on ie_o one cycle after the ei_i, di_i or take that set it. At the next sampled boundary it would also show on take_o, as a maskable request that is accepted or dropped when it should not be. A fault in the priority chain would show as a wrong src_o in the take cycle, exactly one clock after the boundary, when several lines are raised together. A fault in the sampling qualifier would show as a take without a preceding boundary, or as two takes in adjacent cycles when boundary_i is held high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Bit position of the non-maskable trap; the arbiter ranks it first.
  localparam int TRAP_BIT = 0;

  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic ie_q
);
  always_ff @(posedge clk) begin
    if (rst || take_i || clr_i) ie_q <= 1'b0;
    else if (set_i)             ie_q <= 1'b1;
  end

  // R5: disable pulse always wins
  a_r5_di_clears: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !ie_q);
  // R5: enable pulse alone sets the flip-flop
  a_r5_ei_sets: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i && !take_i) |=> ie_q);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_SRC = 5,
  parameter logic [NUM_SRC-1:0] NMI_MASK = NUM_SRC'(1)
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ie_i,
  output logic [NUM_SRC-1:0] elig_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    if (NMI_MASK[g]) begin : g_nmi
      assign elig_o[g] = req_i[g];
    end else begin : g_mask
      assign elig_o[g] = req_i[g] & ie_i;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = irq_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  a_r2_idx_is_set: assert final (!any_o || req_i[idx_o]);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = irq_pkg::idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               boundary_i,
  input  logic               ei_i,
  input  logic               di_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   src_o,
  output logic               push_pc_o,
  output logic               ie_o
);
  localparam logic [NUM_SRC-1:0] NMI_MASK = NUM_SRC'(1) << irq_pkg::TRAP_BIT;

  logic [NUM_SRC-1:0] elig;
  logic               any_elig;
  logic [IDX_W-1:0]   win_idx;
  logic               sample;
  logic               hit;
  logic               take_q;
  logic [IDX_W-1:0]   src_q;

  irq_gate #(.NUM_SRC(NUM_SRC), .NMI_MASK(NMI_MASK)) u_gate (
    .req_i (req_i),
    .ie_i  (ie_o),
    .elig_o(elig)
  );

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i(elig),
    .any_o(any_elig),
    .idx_o(win_idx)
  );

  // A boundary during the take cycle is skipped
  assign sample = boundary_i && !take_q;
  assign hit    = sample && any_elig;

  irq_enable_ff u_ie (
    .clk   (clk),
    .rst   (rst),
    .set_i (ei_i),
    .clr_i (di_i),
    .take_i(hit),
    .ie_q  (ie_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      src_q  <= '0;
    end else begin
      take_q <= hit;
      src_q  <= hit ? win_idx : '0;
    end
  end

  assign take_o    = take_q;
  assign push_pc_o = take_q;
  assign src_o     = src_q;

  // R3: trap at a free boundary is always taken, index 0
  a_r3_trap_taken: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && req_i[irq_pkg::TRAP_BIT] && !take_o) |=> (take_o && src_o == '0));
  // R4: with enable low and no trap, nothing is taken
  a_r4_masked: assert property (@(posedge clk) disable iff (rst)
    (!ie_o && !req_i[irq_pkg::TRAP_BIT]) |=> !take_o);
  // R6: enable is already clear while the take is reported
  a_r6_take_clears_ie: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ie_o);
  // R7: a take always follows a boundary
  a_r7_after_boundary: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i));
  // R8: no adjacent takes
  a_r8_no_back2back: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {ie, req[4:0], exp_take, exp_src[2:0]}
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 5'b00001, 1'b1, 3'd0},
    {1'b1, 5'b00001, 1'b1, 3'd0},
    {1'b1, 5'b10000, 1'b1, 3'd4},
    {1'b0, 5'b10000, 1'b0, 3'd0},
    {1'b1, 5'b11110, 1'b1, 3'd1},
    {1'b1, 5'b11100, 1'b1, 3'd2},
    {1'b1, 5'b11000, 1'b1, 3'd3},
    {1'b0, 5'b11111, 1'b1, 3'd0},
    {1'b0, 5'b11110, 1'b0, 3'd0},
    {1'b1, 5'b00000, 1'b0, 3'd0},
    {1'b1, 5'b10101, 1'b1, 3'd0},
    {1'b1, 5'b01010, 1'b1, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] req = '0;
  logic boundary = 1'b0, ei = 1'b0, di = 1'b0;
  logic take, push, ie;
  logic [2:0] src;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .boundary_i(boundary),
    .ei_i(ei), .di_i(di), .take_o(take), .src_o(src),
    .push_pc_o(push), .ie_o(ie)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req = '0; boundary = 0; ei = 0; di = 0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic enable_ie();
    ei = 1'b1; @(negedge clk); ei = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 take", take, 0); check("R1 push", push, 0);
    check("R1 src", src, 0);   check("R1 ie", ie, 0);

    // R2 R3 R4 R7 R9 vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      if (VEC[v][9]) enable_ie();
      req = VEC[v][8:4]; boundary = 1'b1;
      @(negedge clk);
      req = '0; boundary = 1'b0;
      check($sformatf("R2/R3/R4 take v%0d", v), take, VEC[v][3]);
      check($sformatf("R2 src v%0d", v), src, VEC[v][2:0]);
      check($sformatf("R9 push v%0d", v), push, VEC[v][3]);
      check($sformatf("R6 ie v%0d", v), ie, VEC[v][3] ? 0 : VEC[v][9]);
      @(negedge clk);
      check($sformatf("R7 pulse ends v%0d", v), take, 0);
      check($sformatf("R7 src zero v%0d", v), src, 0);
    end

    // R5 enable / disable, di wins
    do_reset();
    enable_ie(); check("R5 ei sets", ie, 1);
    di = 1'b1; @(negedge clk); di = 1'b0; check("R5 di clears", ie, 0);
    ei = 1'b1; di = 1'b1; @(negedge clk); ei = 1'b0; di = 1'b0;
    check("R5 di wins", ie, 0);

    // R6 take over simultaneous ei; then R4 masked afterwards
    do_reset(); enable_ie();
    req = 5'b10000; boundary = 1'b1; ei = 1'b1;
    @(negedge clk); boundary = 1'b0; ei = 1'b0;
    check("R6 take", take, 1); check("R6 ie clear", ie, 0);
    @(negedge clk);
    req = 5'b00010; boundary = 1'b1;
    @(negedge clk); boundary = 1'b0; req = '0;
    check("R4 masked after take", take, 0);

    // R7 no sampling without boundary
    do_reset(); enable_ie();
    req = 5'b11111;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R7 no boundary", take, 0);
    end
    req = '0;

    // R8 boundary held with trap held
    do_reset();
    req = 5'b00001; boundary = 1'b1;
    @(negedge clk); check("R8 first take", take, 1);
    @(negedge clk); check("R8 gap", take, 0);
    @(negedge clk); check("R8 second take", take, 1);
    req = '0; boundary = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule